// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the addressing byte of a decoded instruction into a memory operand address. It takes the mode and register/memory fields, up to two displacement bytes, the current contents of the two base registers and two index registers, and the four segment registers. From these it forms a 16-bit offset within a segment (the effective address) and a 20-bit physical address. The physical address is the chosen segment value moved up four bit places plus the offset.

The address logic in an execution pipeline drives this block with one request per cycle, flagged by a valid strobe. One clock later it receives the offset, the physical address, the number of displacement bytes that the instruction carries, a flag marking register-to-register operands, and the segment that was used. An optional override input replaces the default segment. Register storage and instruction fetch stay outside the block.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is high, and in the cycle after it, out_valid, ea, pa, disp_len, reg_mode and seg_sel are all zero.
- R2: A request accepted with in_valid high appears on the outputs one clock later, with out_valid high for exactly that cycle. When in_valid is low, ea, pa, disp_len, reg_mode and seg_sel keep their values.
- R3: The addressing byte modrm is split as mode = bits 7:6 and rm = bits 2:0. Bits 5:3 have no effect on any output. Mode 11 is register mode: reg_mode is 1, and ea, pa, disp_len and seg_sel are 0, whatever the override inputs hold.
- R4: Mode 00 uses no displacement (disp_len 0). Mode 01 uses disp_lo alone (disp_len 1). Mode 10 uses {disp_hi, disp_lo} (disp_len 2). disp_len is never 3.
- R5: A one-byte displacement is sign-extended: 00h..7Fh adds 0000h..007Fh and 80h..FFh adds FF80h..FFFFh.
- R6: Mode 00 with rm 110 is a direct address. ea equals {disp_hi, disp_lo}, disp_len is 2, no register is used, and the default segment is the data segment.
- R7: The rm value picks the registers added: 000 bx+si, 001 bx+di, 010 bp+si, 011 bp+di, 100 si, 101 di, 110 bp (except the direct case of R6), 111 bx. The displacement is added to this sum.
- R8: Forms that add bp use the stack segment by default. All other memory forms use the data segment.
- R9: In a memory mode with ovr_en high, seg_sel equals ovr_sel and that segment is used in place of the default.
- R10: The effective address sum wraps modulo 2^16.
- R11: pa = (segment*16 + ea) mod 2^20. seg_sel codes: 00 es, 01 cs, 10 ss, 11 ds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| modrm | input | 8 | Addressing byte (mode, reg, rm) |
| disp_lo | input | 8 | Low displacement byte |
| disp_hi | input | 8 | High displacement byte |
| reg_bx | input | 16 | Base register bx |
| reg_bp | input | 16 | Base register bp |
| reg_si | input | 16 | Index register si |
| reg_di | input | 16 | Index register di |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Override segment code |
| out_valid | output | 1 | Result strobe |
| ea | output | 16 | Effective address |
| pa | output | 20 | Physical address |
| disp_len | output | 2 | Displacement bytes used |
| reg_mode | output | 1 | Register-mode flag |
| seg_sel | output | 2 | Segment code used |

## Verification
The bench goes after the direct-address case, where a design that treats rm 110 in mode 00 as bp would add the stack pointer base and choose the stack segment. It drives one-byte displacements of 7Fh, 80h and FFh; a design that zero-extends them would land 256 bytes too high. It also drives sums that wrap past FFFFh and FFFFFh, where a design that keeps a carry would leave a stray high bit. It covers overrides in register mode and non-zero reg-field bits, which must change nothing, and idle cycles, where the result must be held.

// File: rtl/seg_addr_pkg.sv
`timescale 1ns/1ps
package seg_addr_pkg;
  typedef enum logic [1:0] {
    SEG_ES = 2'b00,
    SEG_CS = 2'b01,
    SEG_SS = 2'b10,
    SEG_DS = 2'b11
  } seg_code_e;

  localparam logic [1:0] MODE_NODISP = 2'b00;
  localparam logic [1:0] MODE_DISP8  = 2'b01;
  localparam logic [1:0] MODE_DISP16 = 2'b10;
  localparam logic [1:0] MODE_REG    = 2'b11;
  localparam logic [2:0] RM_BP_DIRECT = 3'b110;
endpackage

// File: rtl/sea_disp_size.sv
`timescale 1ns/1ps
// Picks the displacement and its length from the mode field; sign-extends single bytes.
module sea_disp_size
  import seg_addr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int OFS_W  = 16
) (
  input  logic [1:0]        mode,
  input  logic [2:0]        rm,
  input  logic [BYTE_W-1:0] lo,
  input  logic [BYTE_W-1:0] hi,
  output logic [OFS_W-1:0]  disp,
  output logic [1:0]        len,
  output logic              direct
);
  localparam int EXT_W = OFS_W - BYTE_W;

  logic [OFS_W-1:0] wide_disp;
  logic [OFS_W-1:0] short_disp;

  assign wide_disp  = {hi, lo};
  assign short_disp = {{EXT_W{lo[BYTE_W-1]}}, lo};
  assign direct     = (mode == MODE_NODISP) && (rm == RM_BP_DIRECT);

  always_comb begin
    disp = '0;
    len  = 2'd0;
    unique case (mode)
      MODE_NODISP: begin
        if (direct) begin
          disp = wide_disp;
          len  = 2'd2;
        end
      end
      MODE_DISP8: begin
        disp = short_disp;
        len  = 2'd1;
      end
      MODE_DISP16: begin
        disp = wide_disp;
        len  = 2'd2;
      end
      default: begin
        disp = '0;
        len  = 2'd0;
      end
    endcase
  end
endmodule

// File: rtl/sea_base_sum.sv
`timescale 1ns/1ps
// Selects base and index registers from rm and adds the displacement (mod 2^OFS_W).
module sea_base_sum #(
  parameter int OFS_W = 16
) (
  input  logic [2:0]       rm,
  input  logic             direct,
  input  logic [OFS_W-1:0] bx,
  input  logic [OFS_W-1:0] bp,
  input  logic [OFS_W-1:0] si,
  input  logic [OFS_W-1:0] di,
  input  logic [OFS_W-1:0] disp,
  output logic [OFS_W-1:0] ea,
  output logic             uses_bp
);
  logic [OFS_W-1:0] base_v;
  logic [OFS_W-1:0] index_v;

  always_comb begin
    base_v  = '0;
    index_v = '0;
    uses_bp = 1'b0;
    unique case (rm)
      3'b000: begin base_v = bx; index_v = si; end
      3'b001: begin base_v = bx; index_v = di; end
      3'b010: begin base_v = bp; index_v = si; uses_bp = 1'b1; end
      3'b011: begin base_v = bp; index_v = di; uses_bp = 1'b1; end
      3'b100: begin index_v = si; end
      3'b101: begin index_v = di; end
      3'b110: begin
        if (!direct) begin
          base_v  = bp;
          uses_bp = 1'b1;
        end
      end
      default: begin base_v = bx; end
    endcase
  end

  assign ea = base_v + index_v + disp;
endmodule

// File: rtl/sea_phys_add.sv
`timescale 1ns/1ps
// Moves the chosen segment up SEG_SHIFT places and adds the offset, wrapping at PHYS_W.
module sea_phys_add #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int N_SEG     = 4,
  parameter int SEL_W     = 2,
  localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
  input  logic [N_SEG-1:0][OFS_W-1:0] segs,
  input  logic [SEL_W-1:0]            sel,
  input  logic [OFS_W-1:0]            ofs,
  output logic [PHYS_W-1:0]           pa
);
  logic [OFS_W-1:0]  seg_v;
  logic [PHYS_W-1:0] seg_base;
  logic [PHYS_W-1:0] ofs_ext;

  assign seg_v    = segs[sel];
  assign seg_base = {seg_v, {SEG_SHIFT{1'b0}}};
  assign ofs_ext  = {{SEG_SHIFT{1'b0}}, ofs};
  assign pa       = seg_base + ofs_ext;
endmodule

// File: rtl/seg_addr_gen.sv
`timescale 1ns/1ps
// Top: effective and physical address from the addressing byte, one-cycle registered result.
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        modrm,
  input  logic [BYTE_W-1:0] disp_lo,
  input  logic [BYTE_W-1:0] disp_hi,
  input  logic [OFS_W-1:0]  reg_bx,
  input  logic [OFS_W-1:0]  reg_bp,
  input  logic [OFS_W-1:0]  reg_si,
  input  logic [OFS_W-1:0]  reg_di,
  input  logic [OFS_W-1:0]  seg_es,
  input  logic [OFS_W-1:0]  seg_cs,
  input  logic [OFS_W-1:0]  seg_ss,
  input  logic [OFS_W-1:0]  seg_ds,
  input  logic              ovr_en,
  input  logic [1:0]        ovr_sel,
  output logic              out_valid,
  output logic [OFS_W-1:0]  ea,
  output logic [PHYS_W-1:0] pa,
  output logic [1:0]        disp_len,
  output logic              reg_mode,
  output logic [1:0]        seg_sel
);
  localparam int N_SEG = 4;

  logic [1:0] mode;
  logic [2:0] rm;
  logic       unused_reg_field;

  assign mode = modrm[7:6];
  assign rm   = modrm[2:0];
  assign unused_reg_field = ^modrm[5:3];

  logic [OFS_W-1:0] disp_c;
  logic [1:0]       len_c;
  logic             direct_c;
  logic [OFS_W-1:0] ea_c;
  logic             bp_c;
  logic [PHYS_W-1:0] pa_c;
  seg_code_e        seg_c;
  logic             regm_c;
  logic [N_SEG-1:0][OFS_W-1:0] seg_bank;

  assign seg_bank[SEG_ES] = seg_es;
  assign seg_bank[SEG_CS] = seg_cs;
  assign seg_bank[SEG_SS] = seg_ss;
  assign seg_bank[SEG_DS] = seg_ds;

  sea_disp_size #(.BYTE_W(BYTE_W), .OFS_W(OFS_W)) u_disp (
    .mode   (mode),
    .rm     (rm),
    .lo     (disp_lo),
    .hi     (disp_hi),
    .disp   (disp_c),
    .len    (len_c),
    .direct (direct_c)
  );

  sea_base_sum #(.OFS_W(OFS_W)) u_sum (
    .rm      (rm),
    .direct  (direct_c),
    .bx      (reg_bx),
    .bp      (reg_bp),
    .si      (reg_si),
    .di      (reg_di),
    .disp    (disp_c),
    .ea      (ea_c),
    .uses_bp (bp_c)
  );

  assign regm_c = (mode == MODE_REG);

  always_comb begin
    if (ovr_en) seg_c = seg_code_e'(ovr_sel);
    else if (bp_c) seg_c = SEG_SS;
    else seg_c = SEG_DS;
  end

  sea_phys_add #(
    .OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT), .N_SEG(N_SEG), .SEL_W(2)
  ) u_phys (
    .segs (seg_bank),
    .sel  (seg_c),
    .ofs  (ea_c),
    .pa   (pa_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ea        <= '0;
      pa        <= '0;
      disp_len  <= 2'd0;
      reg_mode  <= 1'b0;
      seg_sel   <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        reg_mode <= regm_c;
        if (regm_c) begin
          ea       <= '0;
          pa       <= '0;
          disp_len <= 2'd0;
          seg_sel  <= 2'd0;
        end else begin
          ea       <= ea_c;
          pa       <= pa_c;
          disp_len <= len_c;
          seg_sel  <= seg_c;
        end
      end
    end
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
`timescale 1ns/1ps
module seg_addr_gen_chk #(
  parameter int OFS_W  = 16,
  parameter int PHYS_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [7:0]        modrm,
  input logic [7:0]        disp_lo,
  input logic [7:0]        disp_hi,
  input logic              ovr_en,
  input logic [1:0]        ovr_sel,
  input logic              out_valid,
  input logic [OFS_W-1:0]  ea,
  input logic [PHYS_W-1:0] pa,
  input logic [1:0]        disp_len,
  input logic              reg_mode,
  input logic [1:0]        seg_sel
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_drops_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(ea) && $stable(pa) && $stable(seg_sel) && $stable(disp_len)));

  p_reg_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && modrm[7:6] == 2'b11) |=> reg_mode);

  p_reg_zero_r3: assert property (@(posedge clk) disable iff (rst)
    reg_mode |-> (ea == '0 && pa == '0 && disp_len == 2'd0 && seg_sel == 2'd0));

  p_len_byte_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && modrm[7:6] == 2'b01) |=> disp_len == 2'd1);

  p_len_range_r4: assert property (@(posedge clk) disable iff (rst)
    disp_len != 2'd3);

  p_direct_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && modrm[7:6] == 2'b00 && modrm[2:0] == 3'b110)
      |=> (ea == $past({disp_hi, disp_lo}) && disp_len == 2'd2));

  p_override_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ovr_en && modrm[7:6] != 2'b11) |=> seg_sel == $past(ovr_sel));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.OFS_W(OFS_W), .PHYS_W(PHYS_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .modrm(modrm),
  .disp_lo(disp_lo), .disp_hi(disp_hi), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
  .out_valid(out_valid), .ea(ea), .pa(pa), .disp_len(disp_len),
  .reg_mode(reg_mode), .seg_sel(seg_sel)
);

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        in_valid = 1'b0;
  logic [7:0]  modrm = '0, disp_lo = '0, disp_hi = '0;
  logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
  logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic        out_valid;
  logic [15:0] ea;
  logic [19:0] pa;
  logic [1:0]  disp_len;
  logic        reg_mode;
  logic [1:0]  seg_sel;

  seg_addr_gen u_seg_addr_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .modrm(modrm),
    .disp_lo(disp_lo), .disp_hi(disp_hi),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .ovr_en(ovr_en), .ovr_sel(ovr_sel), .out_valid(out_valid),
    .ea(ea), .pa(pa), .disp_len(disp_len), .reg_mode(reg_mode), .seg_sel(seg_sel)
  );

  typedef struct {
    logic [15:0] ea;
    logic [19:0] pa;
    logic [1:0]  len;
    logic        rmode;
    logic [1:0]  seg;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic exp_t model(input logic [7:0] m, input logic [7:0] lo,
                                 input logic [7:0] hi, input logic oe,
                                 input logic [1:0] os, input string tag);
    exp_t e;
    int md = m[7:6];
    int r  = m[2:0];
    int d, sum, segv;
    bit bp_form;
    e.tag = tag;
    if (md == 3) begin
      e.ea = 0; e.pa = 0; e.len = 0; e.rmode = 1; e.seg = 0;
      return e;
    end
    e.rmode = 0;
    if (md == 1) begin d = (lo >= 128) ? int'(lo) - 256 : int'(lo); e.len = 1; end
    else if (md == 2) begin d = int'({hi, lo}); e.len = 2; end
    else begin d = 0; e.len = 0; end
    sum = 0; bp_form = 0;
    if (md == 0 && r == 6) begin
      sum = int'({hi, lo}); e.len = 2;
    end else begin
      if (r == 0 || r == 1 || r == 7) sum += int'(reg_bx);
      if (r == 2 || r == 3 || r == 6) begin sum += int'(reg_bp); bp_form = 1; end
      if (r == 0 || r == 2 || r == 4) sum += int'(reg_si);
      if (r == 1 || r == 3 || r == 5) sum += int'(reg_di);
      sum += d;
    end
    sum = ((sum % 65536) + 65536) % 65536;
    e.ea = sum[15:0];
    e.seg = oe ? os : (bp_form ? 2'b10 : 2'b11);
    case (e.seg)
      2'b00: segv = int'(seg_es);
      2'b01: segv = int'(seg_cs);
      2'b10: segv = int'(seg_ss);
      default: segv = int'(seg_ds);
    endcase
    sum = (segv * 16 + sum) % 1048576;
    e.pa = sum[19:0];
    return e;
  endfunction

  task automatic drive(input logic [7:0] m, input logic [7:0] lo, input logic [7:0] hi,
                       input logic oe, input logic [1:0] os, input string tag);
    @(negedge clk);
    modrm = m; disp_lo = lo; disp_hi = hi; ovr_en = oe; ovr_sel = os;
    in_valid = 1'b1;
    last_exp = model(m, lo, hi, oe, os, tag);
    exp_q.push_back(last_exp);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    modrm = 8'hC5; disp_lo = 8'h5A; disp_hi = 8'hA5; ovr_en = 1'b1; ovr_sel = 2'b01;
  endtask

  task automatic check(input bit ok, input string what, input string act, input string expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", what, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard whenever a result appears.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected out_valid", "1", "0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(ea == e.ea && pa == e.pa && disp_len == e.len && reg_mode == e.rmode
              && seg_sel == e.seg, e.tag,
              $sformatf("ea=%h pa=%h len=%0d rm=%b seg=%0d", ea, pa, disp_len, reg_mode, seg_sel),
              $sformatf("ea=%h pa=%h len=%0d rm=%b seg=%0d", e.ea, e.pa, e.len, e.rmode, e.seg));
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    reg_bx = 16'h1200; reg_bp = 16'h3400; reg_si = 16'h0056; reg_di = 16'h0078;
    seg_es = 16'h1000; seg_cs = 16'h2000; seg_ss = 16'h3000; seg_ds = 16'h4000;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && ea == 0 && pa == 0 && disp_len == 0 && reg_mode == 0
          && seg_sel == 0, "R1 reset state",
          $sformatf("v=%b ea=%h pa=%h", out_valid, ea, pa), "all zero");
    @(negedge clk) rst = 1'b0;
    check(out_valid == 0 && ea == 0 && pa == 0, "R1 after reset",
          $sformatf("v=%b ea=%h", out_valid, ea), "zero");

    // R7 and R8: every rm with no displacement, back to back
    for (int r = 0; r < 8; r++) begin
      if (r != 6) drive({2'b00, 3'b000, 3'(r)}, 8'h00, 8'h00, 1'b0, 2'b00, "R7 R8 rm map mode 00");
    end
    // R6 direct address, reg field set to show R3 independence
    drive(8'b00_111_110, 8'h34, 8'h12, 1'b0, 2'b00, "R6 direct address");
    // R5 one-byte displacement extension
    drive(8'b01_000_111, 8'h7F, 8'hEE, 1'b0, 2'b00, "R5 disp 7F");
    drive(8'b01_000_111, 8'h80, 8'hEE, 1'b0, 2'b00, "R5 disp 80");
    drive(8'b01_000_110, 8'hFF, 8'h00, 1'b0, 2'b00, "R5 R8 disp FF on bp");
    // R4 two-byte displacement
    drive(8'b10_000_011, 8'h22, 8'h11, 1'b0, 2'b00, "R4 disp16 bp+di");
    drive(8'b10_101_100, 8'hF0, 8'h0F, 1'b0, 2'b00, "R4 R3 disp16 si, reg bits set");
    // R3 register mode, with override active
    drive(8'b11_010_001, 8'h12, 8'h34, 1'b1, 2'b01, "R3 register mode with override");
    // R9 overrides
    drive(8'b00_000_010, 8'h00, 8'h00, 1'b1, 2'b00, "R9 override bp form to es");
    drive(8'b01_000_111, 8'h10, 8'h00, 1'b1, 2'b01, "R9 override bx form to cs");

    // R10 effective address wrap
    idle();
    reg_bx = 16'hFFFF; reg_si = 16'h0003; reg_di = 16'hFFF0;
    drive(8'b00_000_000, 8'h00, 8'h00, 1'b0, 2'b00, "R10 ea wrap bx+si");
    drive(8'b10_000_001, 8'h20, 8'h00, 1'b0, 2'b00, "R10 ea wrap bx+di+disp");
    // R11 physical wrap
    idle();
    seg_ds = 16'hFFFF; seg_es = 16'hF000;
    drive(8'b00_000_110, 8'h20, 8'h00, 1'b0, 2'b00, "R11 pa wrap ds");
    drive(8'b10_000_101, 8'h00, 8'h80, 1'b1, 2'b00, "R11 pa es di+disp");

    // R2 hold after idle
    idle();
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R2 out_valid low when idle", $sformatf("%b", out_valid), "0");
    check(ea == last_exp.ea && pa == last_exp.pa && seg_sel == last_exp.seg
          && disp_len == last_exp.len, "R2 outputs held when idle",
          $sformatf("ea=%h pa=%h", ea, pa), $sformatf("ea=%h pa=%h", last_exp.ea, last_exp.pa));
    check(exp_q.size() == 0, "R2 all results delivered",
          $sformatf("%0d", exp_q.size()), "0");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule